// File: doc/BRIEF.md
# Dual-Reference Switchover Controller

This block is the digital control core of a clock generator that can follow either of two reference clocks. Each reference is synchronized into the system clock domain and watched by an activity monitor. The selected reference is passed on to the phase comparator. From the activity of both references, the select input and a force-free-run request, the block settles on one of four modes: locked to the first reference, locked to the second, free run, or unstable.

The block drives an alarm flag that covers loss of the selected reference and loss of lock reported by the loop. It also drives a free-run status flag and a gated output enable. After the selection changes, a qualification timer masks the loss-of-lock part of the alarm while the loop settles on the new reference. Loss of the reference itself is never masked.

The watchdog window and the qualification time are parameters counted in system-clock cycles. A bench can therefore run them short, while a chip sets the window to a few hundred nanoseconds and the qualification time to about half a second.

Top module: `refsw_ctrl`

## Requirements
- R1: `sel_b` = 0 selects reference A and `sel_b` = 1 selects reference B. While the selected reference is active and `force_fr` is 0, `mode` reads 2'b00 when A is selected and 2'b01 when B is selected.
- R2: While `force_fr` = 1, `mode` reads 2'b10 (free run), `fr_stat` reads 1 and `alarm` reads 0, whatever the references are doing.
- R3: With `force_fr` = 0 and both references inactive, `mode` reads 2'b10, `fr_stat` reads 1 and `alarm` reads 1.
- R4: Loss of the reference that is not selected leaves `alarm` at 0 and `mode` locked to the selected reference.
- R5: With `force_fr` = 0, if the selected reference is inactive while the other is active, `mode` reads 2'b11 (unstable) and `alarm` reads 1. This holds until the selection changes or free run is entered.
- R6: In a locked mode and outside the qualification window, `lock_ok` = 0 raises `alarm` one clock later. `lock_ok` = 1 clears it one clock later.
- R7: A change of `sel_b` masks the loss-of-lock part of `alarm` for QUAL+1 clocks, counted from the edge that first samples the new selection. Loss of the selected reference is still alarmed inside that window.
- R8: A reference is active while it has shown a rising edge within the last WIN clocks. After the selected reference stops, `alarm` rises within WIN+6 clocks and not before WIN-6 clocks.
- R9: `oe_n` is active-low: `out_en` equals the inverse of `oe_n` as sampled on the previous clock edge.
- R10: While `rst` = 1, `mode` = 2'b10, `fr_stat` = 1, `alarm` = 0 and `out_en` = 0.
- R11: `cmp_ref` carries the synchronized selected reference while `mode` is not free run, and is held at 0 in free run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | 1 | Reference clock A (asynchronous) |
| ref_b | input | 1 | Reference clock B (asynchronous) |
| sel_b | input | 1 | Reference select, 0 = A, 1 = B |
| force_fr | input | 1 | Force free run, active high |
| oe_n | input | 1 | Output enable, active low |
| lock_ok | input | 1 | Lock indication from the loop, 1 = locked |
| mode | output | 2 | 00 lock A, 01 lock B, 10 free run, 11 unstable |
| alarm | output | 1 | Loss-of-reference or loss-of-lock alarm |
| fr_stat | output | 1 | Free-run status |
| out_en | output | 1 | Gated output enable |
| cmp_ref | output | 1 | Selected reference for the phase comparator |

## Verification
The qualification window and loss of the reference can fall in the same cycles: the selection is switched while the loop reports no lock, and at the same clock the newly selected reference is stopped. The bench expects `alarm` to stay low only until the activity watchdog of the new reference expires. After that it expects `alarm` high and `mode` unstable, well before the blanking window would have ended. A separate run, with the new reference still present, confirms that `alarm` stays at 0 for exactly QUAL+1 clocks and then rises because of loss of lock.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic [1:0] {
    MD_LOCK_A = 2'b00,
    MD_LOCK_B = 2'b01,
    MD_FREE   = 2'b10,
    MD_UNST   = 2'b11
  } mode_e;

  // next mode from the request and the activity of the two references
  function automatic mode_e f_next_mode(input logic frc, input logic act_sel,
                                        input logic act_oth, input logic sel);
    if (frc)                   return MD_FREE;
    else if (!act_sel && !act_oth) return MD_FREE;
    else if (act_sel)          return sel ? MD_LOCK_B : MD_LOCK_A;
    else                       return MD_UNST;
  endfunction

  // alarm for a given next mode
  function automatic logic f_alarm(input mode_e md, input logic frc,
                                   input logic lock, input logic blank);
    case (md)
      MD_FREE: return !frc;
      MD_UNST: return 1'b1;
      default: return !lock && !blank;
    endcase
  endfunction
endpackage

// File: rtl/act_mon.sv
module act_mon #(
  parameter int WIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_sync,
  output logic active
);
  localparam int CW = $clog2(WIN + 1);

  logic s1, s2, s3;
  logic [CW-1:0] since;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ref_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 && !s3;

  // cycles since the last rising edge, saturating at WIN
  always_ff @(posedge clk) begin
    if (rst)                    since <= CW'(WIN);
    else if (rise)              since <= '0;
    else if (since != CW'(WIN)) since <= since + 1'b1;
  end

  assign active   = (since != CW'(WIN));
  assign ref_sync = s2;
endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int QUAL = 125000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic blank
);
  localparam int QW = $clog2(QUAL + 1);

  logic [QW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)            left <= '0;
    else if (start)     left <= QW'(QUAL);
    else if (left != 0) left <= left - 1'b1;
  end

  assign blank = start || (left != 0);
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int WIN  = 64,
  parameter int QUAL = 125000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       sel_b,
  input  logic       force_fr,
  input  logic       oe_n,
  input  logic       lock_ok,
  output logic [1:0] mode,
  output logic       alarm,
  output logic       fr_stat,
  output logic       out_en,
  output logic       cmp_ref
);
  localparam int NREF = 2;

  logic [NREF-1:0] refs, act, rsync;
  logic act_a, act_b, act_sel, act_oth;
  logic sel_q, sel_chg, blank;
  mode_e mode_nxt, mode_q;
  logic alarm_nxt, alarm_q, frs_q, oen_q;

  assign refs = {ref_b, ref_a};

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    act_mon #(.WIN(WIN)) u_mon (
      .clk(clk), .rst(rst), .ref_in(refs[g]),
      .ref_sync(rsync[g]), .active(act[g])
    );
  end

  assign act_a   = act[0];
  assign act_b   = act[1];
  assign act_sel = sel_b ? act_b : act_a;
  assign act_oth = sel_b ? act_a : act_b;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel_b;
  end
  assign sel_chg = sel_b ^ sel_q;

  qual_timer #(.QUAL(QUAL)) u_qual (
    .clk(clk), .rst(rst), .start(sel_chg), .blank(blank)
  );

  assign mode_nxt  = f_next_mode(force_fr, act_sel, act_oth, sel_b);
  assign alarm_nxt = f_alarm(mode_nxt, force_fr, lock_ok, blank);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_FREE;
      alarm_q <= 1'b0;
      frs_q   <= 1'b1;
      oen_q   <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      alarm_q <= alarm_nxt;
      frs_q   <= (mode_nxt == MD_FREE);
      oen_q   <= !oe_n;
    end
  end

  assign mode    = mode_q;
  assign alarm   = alarm_q;
  assign fr_stat = frs_q;
  assign out_en  = oen_q;
  assign cmp_ref = (mode_q == MD_FREE) ? 1'b0 : (sel_b ? rsync[1] : rsync[0]);
endmodule

// File: rtl/refsw_chk.sv
module refsw_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_b,
  input logic       force_fr,
  input logic       oe_n,
  input logic       lock_ok,
  input logic       act_a,
  input logic       act_b,
  input logic       blank,
  input logic [1:0] mode,
  input logic       alarm,
  input logic       fr_stat,
  input logic       out_en
);
  AST_FORCE_FREE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && force_fr) |-> (mode == 2'b10 && fr_stat && !alarm)); // R2

  AST_BOTH_LOST: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !force_fr && !act_a && !act_b) |-> (mode == 2'b10 && fr_stat && alarm)); // R3

  AST_SEL_LOST: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !force_fr && (sel_b ? (!act_b && act_a) : (!act_a && act_b)))
      |-> (mode == 2'b11 && alarm)); // R5

  AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !force_fr && lock_ok && (sel_b ? act_b : act_a))
      |-> (!alarm && mode == {1'b0, $past(sel_b)})); // R4

  AST_LOL_RAISE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !force_fr && !lock_ok && !blank && (sel_b ? act_b : act_a)) |-> alarm); // R6

  AST_BLANK_MASK: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !force_fr && blank && (sel_b ? act_b : act_a)) |-> !alarm); // R7

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (out_en == !$past(oe_n))); // R9

  AST_FRSTAT_MODE: assert property (@(posedge clk) disable iff (rst)
    fr_stat == (mode == 2'b10)); // R2
endmodule

bind refsw_ctrl refsw_chk u_chk (
  .clk(clk), .rst(rst), .sel_b(sel_b), .force_fr(force_fr), .oe_n(oe_n),
  .lock_ok(lock_ok), .act_a(act_a), .act_b(act_b), .blank(blank),
  .mode(mode), .alarm(alarm), .fr_stat(fr_stat), .out_en(out_en)
);

// File: tb/sim_refsw_ctrl.sv
module sim_refsw_ctrl;
  localparam int WIN  = 16;
  localparam int QUAL = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic sel_b = 1'b0, force_fr = 1'b0, oe_n = 1'b0, lock_ok = 1'b1;
  logic run_a = 1'b0, run_b = 1'b0;
  logic [1:0] mode;
  logic alarm, fr_stat, out_en, cmp_ref;
  int da = 0, db = 0;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  refsw_ctrl #(.WIN(WIN), .QUAL(QUAL)) u0 (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b),
    .force_fr(force_fr), .oe_n(oe_n), .lock_ok(lock_ok), .mode(mode),
    .alarm(alarm), .fr_stat(fr_stat), .out_en(out_en), .cmp_ref(cmp_ref)
  );

  // reference sources: A period 6 clocks, B period 8 clocks
  always @(negedge clk) begin
    if (run_a) begin
      if (da == 2) begin da <= 0; ref_a <= ~ref_a; end else da <= da + 1;
    end
    if (run_b) begin
      if (db == 3) begin db <= 0; ref_b <= ~ref_b; end else db <= db + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected {mode, alarm, fr_stat} with lock_ok = 1
  function automatic int expect_st(input int f, input int ra, input int rb, input int s);
    int ss;
    ss = s ? rb : ra;
    if (f != 0)                  return (2 << 2) | (0 << 1) | 1;
    else if (ra == 0 && rb == 0) return (2 << 2) | (1 << 1) | 1;
    else if (ss != 0)            return (s << 2);
    else                         return (3 << 2) | (1 << 1);
  endfunction

  initial begin
    int n, rises;
    logic prev;
    // R10 reset state
    tick(5);
    chk("R10 mode", mode, 2);
    chk("R10 fr_stat", fr_stat, 1);
    chk("R10 alarm", alarm, 0);
    chk("R10 out_en", out_en, 0);
    rst = 1'b0;
    tick(2);

    // sweep over force, activity of both references and select
    for (int f = 0; f < 2; f++)
      for (int ra = 0; ra < 2; ra++)
        for (int rb = 0; rb < 2; rb++)
          for (int s = 0; s < 2; s++) begin
            string tag;
            int ss;
            force_fr = f[0]; run_a = ra[0]; run_b = rb[0]; sel_b = s[0];
            tick(QUAL + WIN + 10);
            ss = s ? rb : ra;
            if (f != 0)                  tag = "R2";
            else if (ra == 0 && rb == 0) tag = "R3";
            else if (ss == 0)            tag = "R5";
            else if (ra == 0 || rb == 0) tag = "R4";
            else                         tag = "R1";
            chk(tag, {mode, alarm, fr_stat}, expect_st(f, ra, rb, s));
          end

    // R6 loss of lock in locked A
    force_fr = 1'b0; run_a = 1'b1; run_b = 1'b1; sel_b = 1'b0; lock_ok = 1'b1;
    tick(QUAL + WIN + 10);
    chk("R1 lock A", mode, 0);
    lock_ok = 1'b0;
    tick(1);
    chk("R6 lol raise", alarm, 1);
    lock_ok = 1'b1;
    tick(1);
    chk("R6 lol clear", alarm, 0);

    // R7 exact blanking window on switch to B with lock lost
    lock_ok = 1'b0;
    tick(2);
    chk("R6 lol before switch", alarm, 1);
    sel_b = 1'b1;
    n = 0;
    for (int i = 0; i < QUAL + 1; i++) begin
      tick(1);
      if (alarm) n++;
    end
    chk("R7 blank cycles alarmed", n, 0);
    chk("R1 lock B", mode, 1);
    tick(1);
    chk("R7 alarm after window", alarm, 1);

    // R7 with R5: new reference lost inside the window
    sel_b = 1'b0; run_a = 1'b0;
    tick(WIN + 8);
    chk("R7 lor not masked", alarm, 1);
    chk("R5 unstable", mode, 3);

    // R8 alarm latency after the selected reference stops
    lock_ok = 1'b1; run_a = 1'b1;
    tick(QUAL + WIN + 10);
    chk("R8 settled alarm", alarm, 0);
    run_a = 1'b0;
    n = 0;
    while (!alarm && n < 100) begin tick(1); n++; end
    chk("R8 latency low bound", (n >= WIN - 6) ? 1 : 0, 1);
    chk("R8 latency high bound", (n <= WIN + 6) ? 1 : 0, 1);

    // R9 output enable gating
    oe_n = 1'b1;
    tick(1);
    chk("R9 disabled", out_en, 0);
    oe_n = 1'b0;
    tick(1);
    chk("R9 enabled", out_en, 1);

    // R11 comparator routing, A selected while B is stopped
    run_a = 1'b1; run_b = 1'b0; sel_b = 1'b0;
    tick(WIN + 10);
    rises = 0; prev = cmp_ref;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if (cmp_ref && !prev) rises++;
      prev = cmp_ref;
    end
    chk("R11 routes A", (rises >= 5) ? 1 : 0, 1);
    // B selected while A is stopped
    run_a = 1'b0; run_b = 1'b1; sel_b = 1'b1;
    tick(WIN + 10);
    rises = 0; prev = cmp_ref;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if (cmp_ref && !prev) rises++;
      prev = cmp_ref;
    end
    chk("R11 routes B", (rises >= 5) ? 1 : 0, 1);
    // forced free run blocks the comparator
    run_a = 1'b1; force_fr = 1'b1;
    tick(3);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if (cmp_ref) n++;
    end
    chk("R11 quiet in free run", n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule